// File: doc/BRIEF.md
# Dual-Sided Mailbox Register File

This block is a small byte-wide register space shared by two agents on one chip: a host side and a management-controller side. Each side has its own synchronous register port with an address, a write strobe, write data, a read strobe and registered read data. The two agents exchange a fourteen-byte message through common data registers. They use doorbells to tell each other when a message or a response is ready. The controller can also post events to the host through two status bytes and a flag byte.

Each side has a control register with a doorbell-pending bit, a mask bit and a send bit. Writing the send bit on one side raises the pending bit on the other side. The owner clears its own pending bit by writing a one to it. Status bits are set by the controller and cleared by the host with write-one-to-clear. Each side has two interrupt-enable bytes that select which status bits drive its interrupt line. Each side's interrupt output combines its unmasked doorbell with its enabled status bits.

Top module: `mbx_regfile`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0x00, both read-data outputs are 0x00 and both interrupt outputs are low.
- R2: Offsets 0x00 to 0x0D are data bytes that either side may write and read. When both sides write the same data byte in one cycle, the controller's value is stored.
- R3: A read strobe sampled at a clock edge loads read data with the register value from before any write at that same edge. Read data holds its value while the read strobe is low.
- R4: Offset 0x0F (flag byte; bit 0 = controller was reset, bit 1 = completion) is written only by the controller. Host writes to it are ignored.
- R5: Offsets 0x10 and 0x11 are status bytes. A controller write sets every bit written as 1. A host write clears every bit written as 1. If a set and a clear hit the same bit in one cycle, the bit ends set.
- R6: Control registers sit at 0x12 (controller side) and 0x13 (host side), with bit 7 = doorbell pending, bit 1 = mask, bit 0 = send. When the owner writes 1 to bit 0, the other side's bit 7 is set at that edge. Bit 0 and bits 6..2 always read 0.
- R7: The owner of a control register clears its bit 7 by writing 1 to it. When a clear and a peer send hit the same cycle, bit 7 ends set.
- R8: Only the owner writes the mask bit of a control register. The other side's writes to that register are ignored.
- R9: Offsets 0x14/0x15 are the controller's enable bytes for status 0x10/0x11, and 0x16/0x17 are the host's. Only the owning side can write them.
- R10: A side's interrupt output is high while its bit 7 is set and its mask is clear, or while any status bit is set whose matching enable bit for that side is set.
- R11: Reads of 0x0E and of any offset above 0x17 return 0x00, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Synchronous active-low reset |
| hst_addr | input | AW | Host register offset |
| hst_wr | input | 1 | Host write strobe |
| hst_wdata | input | DW | Host write data |
| hst_rd | input | 1 | Host read strobe |
| hst_rdata | output | DW | Host read data, registered |
| mgr_addr | input | AW | Controller register offset |
| mgr_wr | input | 1 | Controller write strobe |
| mgr_wdata | input | DW | Controller write data |
| mgr_rd | input | 1 | Controller read strobe |
| mgr_rdata | output | DW | Controller read data, registered |
| hst_irq | output | 1 | Interrupt toward the host |
| mgr_irq | output | 1 | Interrupt toward the controller |

## Verification
The hardest case to reach from the ports is a same-cycle collision. In it, one side sends a doorbell or sets a status bit while the other side clears that same bit, or both sides write one data byte in the same cycle. A single port cannot produce this; both ports must hit paired offsets in the same cycle. Directed steps drive both ports together at the paired offsets. The random phase draws both addresses from a narrow window and biases bits 7 and 0 of the write data, so these collisions occur many times alongside ordinary traffic.

// File: rtl/mbx_pkg.sv
// Package: register map and control-bit positions shared by the mailbox
// modules and its checker. Offsets are derived from the data-byte count,
// so the map stays contiguous if that count changes.
package mbx_pkg;
    localparam int DATA_REGS = 14;               // message bytes at 0x00..
    localparam int OFS_GAP   = DATA_REGS;        // reserved byte, reads zero
    localparam int OFS_FLAG  = DATA_REGS + 1;    // controller event flags
    localparam int N_STAT    = 2;                // status bytes
    localparam int OFS_ST0   = OFS_FLAG + 1;     // first status byte
    localparam int OFS_MCTL  = OFS_ST0 + N_STAT; // controller control reg
    localparam int OFS_HCTL  = OFS_MCTL + 1;     // host control reg
    localparam int IE_HALF   = N_STAT;           // enable bytes per side
    localparam int N_IE      = 2 * IE_HALF;
    localparam int OFS_IE    = OFS_HCTL + 1;     // controller enables first
    localparam int N_REGS    = OFS_IE + N_IE;    // first unmapped offset

    localparam int CTL_PEND  = 7;                // doorbell pending (W1C)
    localparam int CTL_MASK  = 1;                // doorbell mask
    localparam int CTL_SEND  = 0;                // doorbell send, reads 0
endpackage

// File: rtl/mbx_wr_dec.sv
// Module: mbx_wr_dec
// Turns one port's write strobe and address into a one-hot write-hit
// vector across the mapped offsets. Assumes offsets at or above NREG are
// unmapped, so no hit bit exists for them.
module mbx_wr_dec #(
    parameter int AW   = 8,
    parameter int NREG = 24
) (
    input  logic [AW-1:0]   addr,
    input  logic            wr,
    output logic [NREG-1:0] hit
);
    // One comparator per mapped offset.
    for (genvar i = 0; i < NREG; i++) begin : g_hit
        assign hit[i] = wr && (addr == AW'(i));
    end
endmodule

// File: rtl/mbx_setclr.sv
// Module: mbx_setclr
// A register whose bits are set by one vector and cleared by another.
// When both hit the same bit in a cycle, the set takes priority.
// Assumes a synchronous active-low reset to all zeros.
module mbx_setclr #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    // Clear first, then OR in the set bits so a set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) q <= '0;
        else        q <= (q & ~clr) | set;
    end
endmodule

// File: rtl/mbx_doorbell.sv
// Module: mbx_doorbell
// One side's control register: a pending bit that the peer raises and the
// owner clears by writing one, plus an owner-written mask. It also emits
// the owner's send strobe toward the peer. Assumes own_hit is already
// qualified by the owner's write strobe and address.
module mbx_doorbell (
    input  logic clk,
    input  logic rst_n,
    input  logic own_hit,      // owner writes its control register
    input  logic own_clr_bit,  // write data at the pending position
    input  logic own_mask_bit, // write data at the mask position
    input  logic own_send_bit, // write data at the send position
    input  logic peer_send,    // peer's send strobe
    output logic pend,
    output logic mask,
    output logic send
);
    // The send bit is not stored: the write itself is the strobe.
    assign send = own_hit & own_send_bit;

    // Pending bit, where a peer send outranks an owner clear.
    mbx_setclr #(.W(1)) u_pend (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (peer_send),
        .clr   (own_hit & own_clr_bit),
        .q     (pend)
    );

    // Mask bit, written only by the owner.
    always_ff @(posedge clk) begin
        if (!rst_n)       mask <= 1'b0;
        else if (own_hit) mask <= own_mask_bit;
    end
endmodule

// File: rtl/mbx_regfile.sv
// Module: mbx_regfile
// Mailbox register space shared by a host port and a controller port in
// one clock domain. It holds the data bytes, a controller flag byte, the
// set/clear status bytes, two doorbell control registers and the
// per-side interrupt enables. Reads are registered and return the value
// held before any write at the same edge. Assumes DW >= 8 so that the
// control-bit positions exist.
module mbx_regfile
    import mbx_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] hst_addr,
    input  logic          hst_wr,
    input  logic [DW-1:0] hst_wdata,
    input  logic          hst_rd,
    output logic [DW-1:0] hst_rdata,
    input  logic [AW-1:0] mgr_addr,
    input  logic          mgr_wr,
    input  logic [DW-1:0] mgr_wdata,
    input  logic          mgr_rd,
    output logic [DW-1:0] mgr_rdata,
    output logic          hst_irq,
    output logic          mgr_irq
);
    logic [N_REGS-1:0] h_hit, m_hit;
    logic [DW-1:0]     dat  [DATA_REGS];
    logic [DW-1:0]     flag;
    logic [DW-1:0]     stat [N_STAT];
    logic [DW-1:0]     ie   [N_IE];
    logic              h_pend, h_mask, h_send;
    logic              m_pend, m_mask, m_send;
    logic              h_att, m_att;

    // Write-hit decode for each port.
    mbx_wr_dec #(.AW(AW), .NREG(N_REGS)) u_hdec (
        .addr (hst_addr), .wr (hst_wr), .hit (h_hit)
    );
    mbx_wr_dec #(.AW(AW), .NREG(N_REGS)) u_mdec (
        .addr (mgr_addr), .wr (mgr_wr), .hit (m_hit)
    );

    // Write hits that carry no effect (reserved byte, foreign registers).
    logic unused_hits;
    assign unused_hits = h_hit[OFS_GAP] ^ m_hit[OFS_GAP] ^ h_hit[OFS_FLAG]
                       ^ h_hit[OFS_MCTL] ^ m_hit[OFS_HCTL]
                       ^ (^h_hit[OFS_IE +: IE_HALF])
                       ^ (^m_hit[OFS_IE + IE_HALF +: IE_HALF]);

    // Data bytes: both sides write, and the controller wins a collision.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DATA_REGS; i++) begin
            if (!rst_n)         dat[i] <= '0;
            else if (m_hit[i])  dat[i] <= mgr_wdata;
            else if (h_hit[i])  dat[i] <= hst_wdata;
        end
    end

    // Flag byte: written by the controller only.
    always_ff @(posedge clk) begin
        if (!rst_n)              flag <= '0;
        else if (m_hit[OFS_FLAG]) flag <= mgr_wdata;
    end

    // Status bytes: the controller sets bits, the host clears them.
    for (genvar k = 0; k < N_STAT; k++) begin : g_stat
        mbx_setclr #(.W(DW)) u_st (
            .clk   (clk),
            .rst_n (rst_n),
            .set   (m_hit[OFS_ST0 + k] ? mgr_wdata : '0),
            .clr   (h_hit[OFS_ST0 + k] ? hst_wdata : '0),
            .q     (stat[k])
        );
    end

    // Controller-side control register, rung by the host.
    mbx_doorbell u_mdb (
        .clk          (clk),
        .rst_n        (rst_n),
        .own_hit      (m_hit[OFS_MCTL]),
        .own_clr_bit  (mgr_wdata[CTL_PEND]),
        .own_mask_bit (mgr_wdata[CTL_MASK]),
        .own_send_bit (mgr_wdata[CTL_SEND]),
        .peer_send    (h_send),
        .pend         (m_pend),
        .mask         (m_mask),
        .send         (m_send)
    );

    // Host-side control register, rung by the controller.
    mbx_doorbell u_hdb (
        .clk          (clk),
        .rst_n        (rst_n),
        .own_hit      (h_hit[OFS_HCTL]),
        .own_clr_bit  (hst_wdata[CTL_PEND]),
        .own_mask_bit (hst_wdata[CTL_MASK]),
        .own_send_bit (hst_wdata[CTL_SEND]),
        .peer_send    (m_send),
        .pend         (h_pend),
        .mask         (h_mask),
        .send         (h_send)
    );

    // Enable bytes: the lower half belongs to the controller, upper to host.
    always_ff @(posedge clk) begin
        for (int i = 0; i < N_IE; i++) begin
            if (!rst_n)
                ie[i] <= '0;
            else if ((i < IE_HALF) ? m_hit[OFS_IE + i] : h_hit[OFS_IE + i])
                ie[i] <= (i < IE_HALF) ? mgr_wdata : hst_wdata;
        end
    end

    // Enabled status events seen by each side.
    always_comb begin
        m_att = 1'b0;
        h_att = 1'b0;
        for (int k = 0; k < N_STAT; k++) begin
            m_att = m_att | (|(stat[k] & ie[k]));
            h_att = h_att | (|(stat[k] & ie[IE_HALF + k]));
        end
    end

    // Interrupt lines: unmasked doorbell or enabled status event.
    assign mgr_irq = (m_pend & ~m_mask) | m_att;
    assign hst_irq = (h_pend & ~h_mask) | h_att;

    // Readback form of a control register; send and spare bits read 0.
    function automatic logic [DW-1:0] ctl_view(input logic p, input logic m);
        logic [DW-1:0] v;
        v = '0;
        v[CTL_PEND] = p;
        v[CTL_MASK] = m;
        return v;
    endfunction

    // Read multiplexer shared by both ports; unmapped offsets give zero.
    function automatic logic [DW-1:0] rd_mux(input logic [AW-1:0] a);
        logic [DW-1:0] v;
        v = '0;
        for (int i = 0; i < DATA_REGS; i++)
            if (a == AW'(i)) v = dat[i];
        if (a == AW'(OFS_FLAG)) v = flag;
        for (int k = 0; k < N_STAT; k++)
            if (a == AW'(OFS_ST0 + k)) v = stat[k];
        if (a == AW'(OFS_MCTL)) v = ctl_view(m_pend, m_mask);
        if (a == AW'(OFS_HCTL)) v = ctl_view(h_pend, h_mask);
        for (int i = 0; i < N_IE; i++)
            if (a == AW'(OFS_IE + i)) v = ie[i];
        return v;
    endfunction

    // Registered read data for each port, held while no read is issued.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hst_rdata <= '0;
            mgr_rdata <= '0;
        end else begin
            if (hst_rd) hst_rdata <= rd_mux(hst_addr);
            if (mgr_rd) mgr_rdata <= rd_mux(mgr_addr);
        end
    end
endmodule

// File: rtl/mbx_regfile_chk.sv
// Module: mbx_regfile_chk
// Property checker for mbx_regfile, attached by the bind at the end of
// this file. It watches the ports plus the doorbell and status state.
module mbx_regfile_chk
    import mbx_pkg::*;
#(
    parameter int AW = 8,
    parameter int DW = 8
) (
    input logic          clk,
    input logic          rst_n,
    input logic [AW-1:0] hst_addr,
    input logic          hst_wr,
    input logic [DW-1:0] hst_wdata,
    input logic          hst_rd,
    input logic [DW-1:0] hst_rdata,
    input logic [AW-1:0] mgr_addr,
    input logic          mgr_wr,
    input logic [DW-1:0] mgr_wdata,
    input logic          hst_irq,
    input logic          mgr_irq,
    input logic          h_pend,
    input logic          h_mask,
    input logic          m_pend,
    input logic [DW-1:0] stat1
);
    logic h_ring, m_clr;
    assign h_ring = hst_wr && (hst_addr == AW'(OFS_HCTL)) && hst_wdata[CTL_SEND];
    assign m_clr  = mgr_wr && (mgr_addr == AW'(OFS_MCTL)) && mgr_wdata[CTL_PEND];

    // R1: a cycle in reset leaves both interrupt lines low.
    a_r1_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!hst_irq && !mgr_irq));

    // R5: a controller write to the second status byte sets those bits.
    a_r5_status_set: assert property (@(posedge clk) disable iff (!rst_n)
        (mgr_wr && mgr_addr == AW'(OFS_ST0 + 1))
        |=> ((stat1 & $past(mgr_wdata)) == $past(mgr_wdata)));

    // R6: a host send raises the controller's pending bit.
    a_r6_send_rings_peer: assert property (@(posedge clk) disable iff (!rst_n)
        h_ring |=> m_pend);

    // R7: an owner clear with no competing send drops the pending bit.
    a_r7_w1c_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (m_clr && !h_ring) |=> !m_pend);

    // R7: a clear colliding with a send leaves the bit set.
    a_r7_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (m_clr && h_ring) |=> m_pend);

    // R10: an unmasked pending doorbell drives the host interrupt.
    a_r10_irq_follows: assert property (@(posedge clk) disable iff (!rst_n)
        (h_pend && !h_mask) |-> hst_irq);

    // R11: reading the reserved byte returns zero.
    a_r11_gap_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (hst_rd && hst_addr == AW'(OFS_GAP)) |=> (hst_rdata == '0));
endmodule

bind mbx_regfile mbx_regfile_chk #(.AW(AW), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .hst_addr  (hst_addr),
    .hst_wr    (hst_wr),
    .hst_wdata (hst_wdata),
    .hst_rd    (hst_rd),
    .hst_rdata (hst_rdata),
    .mgr_addr  (mgr_addr),
    .mgr_wr    (mgr_wr),
    .mgr_wdata (mgr_wdata),
    .hst_irq   (hst_irq),
    .mgr_irq   (mgr_irq),
    .h_pend    (h_pend),
    .h_mask    (h_mask),
    .m_pend    (m_pend),
    .stat1     (stat[1])
);

// File: tb/tb_mbx_regfile.sv
// Bench for mbx_regfile: directed corner cases followed by seeded random
// traffic on both ports, compared against a register model kept here.
module tb_mbx_regfile;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] hst_addr = '0, hst_wdata = '0, mgr_addr = '0, mgr_wdata = '0;
    logic       hst_wr = 1'b0, hst_rd = 1'b0, mgr_wr = 1'b0, mgr_rd = 1'b0;
    logic [7:0] hst_rdata, mgr_rdata;
    logic       hst_irq, mgr_irq;

    int vecs = 0;
    int miss = 0;
    logic [7:0] mdl [0:23];
    logic [7:0] exp_hr = '0, exp_mr = '0;

    always #10 clk = ~clk; // 50 MHz

    mbx_regfile dut (
        .clk (clk), .rst_n (rst_n),
        .hst_addr (hst_addr), .hst_wr (hst_wr), .hst_wdata (hst_wdata),
        .hst_rd (hst_rd), .hst_rdata (hst_rdata),
        .mgr_addr (mgr_addr), .mgr_wr (mgr_wr), .mgr_wdata (mgr_wdata),
        .mgr_rd (mgr_rd), .mgr_rdata (mgr_rdata),
        .hst_irq (hst_irq), .mgr_irq (mgr_irq)
    );

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", vecs, miss);
        $finish;
    endtask

    // Watchdog: a hung run counts as one failure.
    initial begin
        repeat (200000) @(posedge clk);
        miss++;
        $display("FAIL watchdog: got timeout expected completion");
        summary();
    end

    function automatic logic [7:0] m_read(input int a);
        return (a < 24) ? mdl[a] : 8'h00;
    endfunction

    function automatic logic h_irq_exp();
        return (mdl[19][7] & ~mdl[19][1]) | (|(mdl[16] & mdl[22])) | (|(mdl[17] & mdl[23]));
    endfunction

    function automatic logic m_irq_exp();
        return (mdl[18][7] & ~mdl[18][1]) | (|(mdl[16] & mdl[20])) | (|(mdl[17] & mdl[21]));
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
        vecs++;
        if (act !== exp) begin
            miss++;
            $display("FAIL %s %s: got %h expected %h", tag, what, act, exp);
        end
    endtask

    // One cycle of both ports; updates the model and compares all outputs.
    task automatic step(input logic hw, input logic [7:0] ha, input logic [7:0] hd,
                        input logic hr, input logic mw, input logic [7:0] ma,
                        input logic [7:0] md, input logic mr, input string tag);
        logic [7:0] nm [0:23];
        int hai, mai;
        logic hs, ms;
        @(negedge clk);
        hst_wr = hw; hst_addr = ha; hst_wdata = hd; hst_rd = hr;
        mgr_wr = mw; mgr_addr = ma; mgr_wdata = md; mgr_rd = mr;
        hai = int'(ha); mai = int'(ma);
        if (hr) exp_hr = m_read(hai);
        if (mr) exp_mr = m_read(mai);
        for (int i = 0; i < 24; i++) nm[i] = mdl[i];
        if (hw && hai < 14) nm[hai] = hd;
        if (mw && mai < 14) nm[mai] = md;
        if (mw && mai == 15) nm[15] = md;
        for (int k = 16; k < 18; k++)
            nm[k] = (mdl[k] & ~((hw && hai == k) ? hd : 8'h00))
                  | ((mw && mai == k) ? md : 8'h00);
        hs = hw && hai == 19 && hd[0];
        ms = mw && mai == 18 && md[0];
        nm[18] = 8'h00;
        nm[18][7] = (mdl[18][7] & ~(mw && mai == 18 && md[7])) | hs;
        nm[18][1] = (mw && mai == 18) ? md[1] : mdl[18][1];
        nm[19] = 8'h00;
        nm[19][7] = (mdl[19][7] & ~(hw && hai == 19 && hd[7])) | ms;
        nm[19][1] = (hw && hai == 19) ? hd[1] : mdl[19][1];
        if (mw && (mai == 20 || mai == 21)) nm[mai] = md;
        if (hw && (hai == 22 || hai == 23)) nm[hai] = hd;
        @(posedge clk);
        #2;
        for (int i = 0; i < 24; i++) mdl[i] = nm[i];
        chk(tag, "hst_rdata", hst_rdata, exp_hr);
        chk(tag, "mgr_rdata", mgr_rdata, exp_mr);
        chk(tag, "hst_irq", {7'd0, hst_irq}, {7'd0, h_irq_exp()});
        chk(tag, "mgr_irq", {7'd0, mgr_irq}, {7'd0, m_irq_exp()});
    endtask

    task automatic hread(input logic [7:0] a, input string tag);
        step(0, a, 0, 1, 0, 0, 0, 0, tag);
    endtask
    task automatic mread(input logic [7:0] a, input string tag);
        step(0, 0, 0, 0, 0, a, 0, 1, tag);
    endtask
    task automatic hwrite(input logic [7:0] a, input logic [7:0] d, input string tag);
        step(1, a, d, 0, 0, 0, 0, 0, tag);
    endtask
    task automatic mwrite(input logic [7:0] a, input logic [7:0] d, input string tag);
        step(0, 0, 0, 0, 1, a, d, 0, tag);
    endtask

    initial begin
        for (int i = 0; i < 24; i++) mdl[i] = 8'h00;
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        #2;
        // R1: outputs during and after reset
        chk("R1", "hst_rdata", hst_rdata, 8'h00);
        chk("R1", "hst_irq", {7'd0, hst_irq}, 8'h00);
        @(negedge clk); rst_n = 1'b1;
        step(0, 8'h13, 0, 1, 0, 8'h12, 0, 1, "R1");
        step(0, 8'h11, 0, 1, 0, 8'h17, 0, 1, "R1");

        // R2: shared data bytes and controller priority on collision
        hwrite(8'h05, 8'hA5, "R2");
        mread(8'h05, "R2");
        mwrite(8'h0D, 8'h3C, "R2");
        hread(8'h0D, "R2");
        step(1, 8'h03, 8'h11, 0, 1, 8'h03, 8'h22, 0, "R2");
        step(0, 8'h03, 0, 1, 0, 8'h03, 0, 1, "R2");

        // R3: read sees the value from before a same-edge write
        step(1, 8'h07, 8'h99, 0, 0, 8'h07, 0, 1, "R3");
        step(0, 0, 0, 0, 0, 0, 0, 0, "R3");
        mread(8'h07, "R3");

        // R4: flag byte is controller-owned
        hwrite(8'h0F, 8'hFF, "R4");
        hread(8'h0F, "R4");
        mwrite(8'h0F, 8'h03, "R4");
        hread(8'h0F, "R4");

        // R5: status set by controller, cleared by host, set wins
        mwrite(8'h11, 8'h80, "R5");
        hread(8'h11, "R5");
        step(1, 8'h11, 8'h80, 0, 1, 8'h11, 8'h80, 0, "R5");
        hread(8'h11, "R5");
        hwrite(8'h11, 8'h80, "R5");
        hread(8'h11, "R5");

        // R6 and R10: host rings the controller; send bit reads 0
        hwrite(8'h13, 8'h01, "R6");
        mread(8'h12, "R6");
        hread(8'h13, "R6");
        mwrite(8'h12, 8'h01, "R6");
        hread(8'h13, "R10");

        // R7: owner clear, and clear colliding with a peer send
        mwrite(8'h12, 8'h80, "R7");
        step(1, 8'h13, 8'h01, 0, 1, 8'h12, 8'h80, 0, "R7");
        mread(8'h12, "R7");
        mwrite(8'h12, 8'h80, "R7");
        hwrite(8'h13, 8'h80, "R7");

        // R8: mask suppresses the doorbell, foreign write ignored
        mwrite(8'h12, 8'h02, "R8");
        hwrite(8'h13, 8'h01, "R8");
        hwrite(8'h12, 8'h00, "R8");
        mread(8'h12, "R8");
        mwrite(8'h12, 8'h80, "R8");

        // R9: enables are side-owned; host enable routes status to host irq
        hwrite(8'h14, 8'hFF, "R9");
        mread(8'h14, "R9");
        hwrite(8'h17, 8'h80, "R9");
        mwrite(8'h11, 8'h80, "R9");
        mwrite(8'h15, 8'h80, "R10");
        hwrite(8'h11, 8'h80, "R10");

        // R11: reserved and unmapped offsets
        step(1, 8'h0E, 8'h5A, 0, 1, 8'h0E, 8'h5A, 0, "R11");
        hread(8'h0E, "R11");
        hwrite(8'h30, 8'h77, "R11");
        mwrite(8'hFF, 8'h77, "R11");
        step(0, 8'h30, 0, 1, 0, 8'hFF, 0, 1, "R11");

        // Random traffic on both ports from a narrow address window
        for (int n = 0; n < 3000; n++) begin
            logic [7:0] ha, ma, hd, md;
            ha = 8'($urandom % 26);
            ma = 8'($urandom % 26);
            if (($urandom % 16) == 0) ha = 8'hFF;
            hd = 8'($urandom);
            md = 8'($urandom);
            if (($urandom % 4) == 0) hd[0] = 1'b1;
            if (($urandom % 4) == 0) md[7] = 1'b1;
            step(1'($urandom), ha, hd, 1'($urandom), 1'($urandom), ma, md,
                 1'($urandom), "RND");
        end
        summary();
    end
endmodule